// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge serves a 32 MB alias window in which every 32-bit alias word stands for one bit of an underlying memory region. A requester on the slave port presents a window offset, an access size and, for writes, a data word whose bit 0 is the new bit value. The bridge works out the underlying byte address and the bit index, then runs transactions on its master port toward real memory.

A read fetches the containing unit of the requested size and returns the addressed bit alone. A write fetches the same unit, sets or clears the one bit, and writes the unit back. The slave port stays busy from acceptance until the response, so no other access through this port can land between the fetch and the write-back. Errors from memory are passed back to the requester.

The base of the underlying region is a parameter, so two copies serve two regions. One copy might map the alias at 0x2200_0000 onto 0x2000_0000 and another might map 0x4200_0000 onto 0x4000_0000.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is held and after it is released, `s_ready` is 1, `m_valid` is 0 and `s_rsp_valid` is 0. Each response lasts exactly one cycle, and `s_ready` returns to 1 in the cycle after it.
- R2: The memory address is `BASE | (s_offset >> 5)`, rounded down to a multiple of the access size. The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R3: The bit index is `(s_offset >> 2) & (8*bytes - 1)`, counted in the little-endian unit of that size. Byte `bitindex>>3` sits at address + byte number, and the bit within it is `bitindex & 7`.
- R4: A read issues one memory read (`m_write`=0) with `m_size` equal to the request size. It responds with the selected bit in `s_rdata[0]` and zeros in all other bits.
- R5: A write issues a memory read and then a memory write, both to the same address and size. The written unit equals the fetched unit with the selected bit replaced by `s_wdata[0]`. `m_wdata` bits above the access size are zero, and the response has `s_rdata` = 0 and `s_err` = 0.
- R6: If the memory read returns `m_err`=1, the response carries `s_err`=1 and `s_rdata`=0, and no memory write is issued.
- R7: If the write-back returns `m_err`=1, the response carries `s_err`=1.
- R8: From the cycle after a request is accepted until its response has been given, `s_ready` is 0.
- R9: A request with size code 3 gets a response with `s_err`=1 and issues no memory transaction.
- R10: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_addr`, `m_write`, `m_size` and `m_wdata` hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Request present on the alias side |
| s_ready | output | 1 | Bridge idle; request accepted when both are 1 |
| s_write | input | 1 | 1 = write the bit, 0 = read it |
| s_offset | input | WIN_W (25) | Byte offset into the alias window |
| s_size | input | 2 | Access size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = invalid |
| s_wdata | input | DATA_W (32) | Write data; only bit 0 is used |
| s_rsp_valid | output | 1 | One-cycle response strobe |
| s_rdata | output | DATA_W (32) | Response data: the bit in bit 0 for reads |
| s_err | output | 1 | Response error flag |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory accepts the request |
| m_write | output | 1 | Memory request is a write |
| m_addr | output | ADDR_W (32) | Size-aligned memory byte address |
| m_size | output | 2 | Memory access size code |
| m_wdata | output | DATA_W (32) | Write-back unit, right-justified, little-endian |
| m_rsp_valid | input | 1 | Memory response strobe |
| m_rdata | input | DATA_W (32) | Fetched unit, right-justified, little-endian |
| m_err | input | 1 | Memory response error |

## Verification
A wrong address or bit index in the latched request shows at the ports in one of two ways. On the first memory request, `m_addr` differs from the expected address. A wrong bit index shows in the read response or in the written unit, at the end of that same access. A corrupt sequencer state shows within a transaction, in one of three ways:
- `s_ready` rising early.
- A write-back issued after a read error.
- A response that never comes, which the per-access timeout catches.

A bad merge can leave a neighbouring bit changed in memory. The bench compares every byte of the touched unit against its own shadow copy straight after each write.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

    // Sequencer states of the bridge.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WR_REQ  = 3'd3,
        ST_WR_WAIT = 3'd4,
        ST_RESP    = 3'd5
    } bb_state_e;

    // Access size codes shared by both ports.
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Alias bytes per underlying byte: 8 bits x 4 bytes per alias word.
    localparam int unsigned ALIAS_SHIFT = 5;

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
    import bitband_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WIN_W  = 25,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000,
    localparam int unsigned BIT_W = $clog2(DATA_W)
) (
    input  logic [WIN_W-1:0]  offset,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BIT_W-1:0]  bitpos,
    output logic              size_ok
);
    localparam int unsigned IDX_W = WIN_W - ALIAS_SHIFT;

    logic [ADDR_W-1:0] word_idx;
    logic [ADDR_W-1:0] low_mask;
    logic [BIT_W-1:0]  bit_mask;
    logic [1:0]        unused_word_sel;

    assign unused_word_sel = offset[1:0];
    assign word_idx = {{(ADDR_W-IDX_W){1'b0}}, offset[WIN_W-1:ALIAS_SHIFT]};

    always_comb begin
        size_ok  = 1'b1;
        low_mask = '0;
        bit_mask = BIT_W'(7);
        case (size)
            SZ_BYTE: begin
                low_mask = '0;
                bit_mask = BIT_W'(7);
            end
            SZ_HALF: begin
                low_mask = ADDR_W'(1);
                bit_mask = BIT_W'(15);
            end
            SZ_WORD: begin
                low_mask = ADDR_W'(3);
                bit_mask = BIT_W'(31);
            end
            default: begin
                size_ok  = 1'b0;
                low_mask = '0;
                bit_mask = '0;
            end
        endcase
        mem_addr = (BASE | word_idx) & ~low_mask;
        bitpos   = offset[BIT_W+1:2] & bit_mask;
    end

endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BIT_W  = $clog2(DATA_W),
    localparam int unsigned NBYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] fetched,
    input  logic [1:0]        size,
    input  logic [BIT_W-1:0]  bitpos,
    input  logic              wbit,
    output logic              bit_out,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] keep;

    // Byte lanes inside the access size are kept; lanes above are zeroed.
    for (genvar gj = 0; gj < NBYTES; gj++) begin : g_lane
        assign keep[gj*8 +: 8] = {8{((gj >> size) == 0)}};
    end

    // Every bit either takes the new value or passes the kept fetched bit.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        assign merged[gi] = (bitpos == BIT_W'(gi)) ? wbit : (fetched[gi] & keep[gi]);
    end

    assign bit_out = fetched[bitpos];

endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bitband_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    // request side
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_write,
    input  logic [1:0]        s_size,
    input  logic              s_wbit,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [BIT_W-1:0]  map_bitpos,
    input  logic              map_size_ok,
    output logic              s_rsp_valid,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_err,
    // bit lane
    output logic [1:0]        lane_size,
    output logic [BIT_W-1:0]  lane_bitpos,
    output logic              lane_wbit,
    input  logic              lane_bit,
    input  logic [DATA_W-1:0] lane_merged,
    // memory side
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_rsp_valid,
    input  logic              m_err
);
    typedef struct packed {
        bb_state_e         st;
        logic              wr;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bitpos;
        logic              wbit;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (s_valid) begin
                    seq_d.wr     = s_write;
                    seq_d.size   = s_size;
                    seq_d.addr   = map_addr;
                    seq_d.bitpos = map_bitpos;
                    seq_d.wbit   = s_wbit;
                    seq_d.rdata  = '0;
                    seq_d.data   = '0;
                    if (map_size_ok) begin
                        seq_d.err = 1'b0;
                        seq_d.st  = ST_RD_REQ;
                    end else begin
                        seq_d.err = 1'b1;
                        seq_d.st  = ST_RESP;
                    end
                end
            end
            ST_RD_REQ: begin
                if (m_ready) seq_d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (m_rsp_valid) begin
                    if (m_err) begin
                        seq_d.err   = 1'b1;
                        seq_d.rdata = '0;
                        seq_d.st    = ST_RESP;
                    end else if (!seq_q.wr) begin
                        seq_d.rdata = {{(DATA_W-1){1'b0}}, lane_bit};
                        seq_d.st    = ST_RESP;
                    end else begin
                        seq_d.data = lane_merged;
                        seq_d.st   = ST_WR_REQ;
                    end
                end
            end
            ST_WR_REQ: begin
                if (m_ready) seq_d.st = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (m_rsp_valid) begin
                    seq_d.err   = m_err;
                    seq_d.rdata = '0;
                    seq_d.st    = ST_RESP;
                end
            end
            ST_RESP: begin
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign s_ready     = (seq_q.st == ST_IDLE);
    assign s_rsp_valid = (seq_q.st == ST_RESP);
    assign s_rdata     = s_rsp_valid ? seq_q.rdata : '0;
    assign s_err       = s_rsp_valid & seq_q.err;
    assign m_valid     = (seq_q.st == ST_RD_REQ) || (seq_q.st == ST_WR_REQ);
    assign m_write     = (seq_q.st == ST_WR_REQ);
    assign m_addr      = seq_q.addr;
    assign m_size      = seq_q.size;
    assign m_wdata     = (seq_q.st == ST_WR_REQ) ? seq_q.data : '0;
    assign lane_size   = seq_q.size;
    assign lane_bitpos = seq_q.bitpos;
    assign lane_wbit   = seq_q.wbit;

    // Accepting a request makes the port busy in the next cycle.
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);

    // A stalled memory request keeps its contents.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)
                                   && $stable(m_size) && $stable(m_wdata)));

    // A failed fetch ends in an error response, never a write-back.
    assert_rd_err_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RD_WAIT && m_rsp_valid && m_err) |=> (s_rsp_valid && s_err && !m_valid));

    // The bad size code never reaches memory.
    assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !map_size_ok) |=> (s_rsp_valid && s_err && !m_valid));

    // The response strobe lasts one cycle and frees the port.
    assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |=> (!s_rsp_valid && s_ready));

    // A response carries at most the single bit.
    assert_rsp_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |-> (s_rdata[DATA_W-1:1] == '0));

    // A write-back follows only a successful fetch of the same request.
    assert_wb_after_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_write) |-> $past(seq_q.st == ST_RD_WAIT && m_rsp_valid && !m_err));

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bitband_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WIN_W  = 25,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_write,
    input  logic [WIN_W-1:0]  s_offset,
    input  logic [1:0]        s_size,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_rsp_valid,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_err,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_rsp_valid,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_err
);
    localparam int unsigned BIT_W = $clog2(DATA_W);

    logic [ADDR_W-1:0] map_addr;
    logic [BIT_W-1:0]  map_bitpos;
    logic              map_size_ok;
    logic [1:0]        lane_size;
    logic [BIT_W-1:0]  lane_bitpos;
    logic              lane_wbit;
    logic              lane_bit;
    logic [DATA_W-1:0] lane_merged;
    logic [DATA_W-2:0] unused_wdata_hi;

    assign unused_wdata_hi = s_wdata[DATA_W-1:1];

    bb_addr_map #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W),
        .DATA_W (DATA_W),
        .BASE   (BASE)
    ) u_map (
        .offset   (s_offset),
        .size     (s_size),
        .mem_addr (map_addr),
        .bitpos   (map_bitpos),
        .size_ok  (map_size_ok)
    );

    bb_bit_lane #(
        .DATA_W (DATA_W)
    ) u_lane (
        .fetched (m_rdata),
        .size    (lane_size),
        .bitpos  (lane_bitpos),
        .wbit    (lane_wbit),
        .bit_out (lane_bit),
        .merged  (lane_merged)
    );

    bb_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_valid     (s_valid),
        .s_ready     (s_ready),
        .s_write     (s_write),
        .s_size      (s_size),
        .s_wbit      (s_wdata[0]),
        .map_addr    (map_addr),
        .map_bitpos  (map_bitpos),
        .map_size_ok (map_size_ok),
        .s_rsp_valid (s_rsp_valid),
        .s_rdata     (s_rdata),
        .s_err       (s_err),
        .lane_size   (lane_size),
        .lane_bitpos (lane_bitpos),
        .lane_wbit   (lane_wbit),
        .lane_bit    (lane_bit),
        .lane_merged (lane_merged),
        .m_valid     (m_valid),
        .m_ready     (m_ready),
        .m_write     (m_write),
        .m_addr      (m_addr),
        .m_size      (m_size),
        .m_wdata     (m_wdata),
        .m_rsp_valid (m_rsp_valid),
        .m_err       (m_err)
    );

    // Memory requests are aligned to their own size.
    assert_half_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_size == SZ_HALF) |-> !m_addr[0]);
    assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_size == SZ_WORD) |-> (m_addr[1:0] == 2'b00));

    // Write-back data never spills past its access size.
    assert_wb_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_write && m_size == SZ_BYTE) |-> (m_wdata[DATA_W-1:8] == '0));

endmodule

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic        s_write = 1'b0;
    logic [24:0] s_offset = '0;
    logic [1:0]  s_size = '0;
    logic [31:0] s_wdata = '0;
    logic        s_rsp_valid;
    logic [31:0] s_rdata;
    logic        s_err;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic        m_write;
    logic [31:0] m_addr;
    logic [1:0]  m_size;
    logic [31:0] m_wdata;
    logic        m_rsp_valid = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        m_err = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitband_bridge #(.BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write),
        .s_offset(s_offset), .s_size(s_size), .s_wdata(s_wdata),
        .s_rsp_valid(s_rsp_valid), .s_rdata(s_rdata), .s_err(s_err),
        .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
        .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
        .m_rsp_valid(m_rsp_valid), .m_rdata(m_rdata), .m_err(m_err)
    );

    // ---------------- memory model ----------------
    logic [7:0]  mem  [256];
    logic [7:0]  gold [256];
    logic [7:0]  lfsr = 8'hA5;
    logic        inj_rd = 1'b0;
    logic        inj_wr = 1'b0;
    logic        pend = 1'b0;
    logic        pend_wr = 1'b0;
    logic [31:0] pend_addr = '0;
    logic [1:0]  pend_size = '0;
    logic [31:0] pend_wdata = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_rd_addr = '0;
    logic [1:0]  last_rd_size = '0;
    logic [31:0] last_wr_addr = '0;
    logic [1:0]  last_wr_size = '0;
    logic [31:0] last_wr_data = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i * 37 + 5);
            gold[i] = 8'(i * 37 + 5);
        end
    end

    function automatic logic [31:0] fetch_mem(input logic [31:0] a, input int nb);
        logic [31:0] w = '0;
        for (int k = 0; k < nb; k++) w[k*8 +: 8] = mem[(a[7:0] + k) & 8'hFF];
        return w;
    endfunction

    function automatic logic [31:0] fetch_gold(input logic [31:0] a, input int nb);
        logic [31:0] w = '0;
        for (int k = 0; k < nb; k++) w[k*8 +: 8] = gold[(a[7:0] + k) & 8'hFF];
        return w;
    endfunction

    always @(posedge clk) begin
        m_rsp_valid <= 1'b0;
        m_err       <= 1'b0;
        m_rdata     <= '0;
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        m_ready <= lfsr[0] | lfsr[3];
        if (pend) begin
            m_rsp_valid <= 1'b1;
            pend <= 1'b0;
            if (pend_wr) begin
                m_err <= inj_wr;
                if (!inj_wr)
                    for (int k = 0; k < (1 << pend_size); k++)
                        mem[(pend_addr[7:0] + k) & 8'hFF] <= pend_wdata[k*8 +: 8];
            end else begin
                m_err   <= inj_rd;
                m_rdata <= inj_rd ? 32'h0 : fetch_mem(pend_addr, 1 << pend_size);
            end
        end
        if (rst_n && m_valid && m_ready) begin
            pend       <= 1'b1;
            pend_wr    <= m_write;
            pend_addr  <= m_addr;
            pend_size  <= m_size;
            pend_wdata <= m_wdata;
            if (m_write) begin
                wr_cnt <= wr_cnt + 1;
                last_wr_addr <= m_addr;
                last_wr_size <= m_size;
                last_wr_data <= m_wdata;
            end else begin
                rd_cnt <= rd_cnt + 1;
                last_rd_addr <= m_addr;
                last_rd_size <= m_size;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Stalled memory requests must hold (R10), sampled mid-cycle.
    logic        was_stalled = 1'b0;
    logic [31:0] stall_addr = '0;
    logic        stall_wr = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (was_stalled) begin
                chk(m_valid && m_addr == stall_addr && m_write == stall_wr, "R10",
                    "stalled request changed", m_addr, stall_addr);
            end
            was_stalled = m_valid && !m_ready;
            stall_addr  = m_addr;
            stall_wr    = m_write;
        end else begin
            was_stalled = 1'b0;
        end
    end

    // ---------------- request driver ----------------
    task automatic run_op(input logic wr, input logic [24:0] off, input logic [1:0] sz,
                          input logic wbit, output logic [31:0] rdata, output logic err);
        int t;
        @(negedge clk);
        s_valid  = 1'b1;
        s_write  = wr;
        s_offset = off;
        s_size   = sz;
        s_wdata  = {31'h5A5A_5A5A, wbit};
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0;
        chk(!s_ready, "R8", "s_ready high while busy", 32'(s_ready), 32'h0);
        t = 0;
        while (!s_rsp_valid && t < 1000) begin
            @(negedge clk);
            t++;
        end
        chk(s_rsp_valid, "R1", "no response", 32'(s_rsp_valid), 32'h1);
        rdata = s_rdata;
        err   = s_err;
        @(negedge clk);
        chk(!s_rsp_valid && s_ready, "R1", "response not a single pulse",
            {30'h0, s_rsp_valid, s_ready}, 32'h1);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic        wr;
        logic [24:0] off;
        logic [1:0]  sz;
        logic        wbit;
        logic [31:0] exp_addr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 25'h000_0000, 2'd0, 1'b0, 32'h2000_0000},
        '{1'b0, 25'h000_001C, 2'd0, 1'b0, 32'h2000_0000},
        '{1'b1, 25'h000_001C, 2'd0, 1'b1, 32'h2000_0000},
        '{1'b0, 25'h000_001C, 2'd0, 1'b0, 32'h2000_0000},
        '{1'b1, 25'h000_0024, 2'd1, 1'b0, 32'h2000_0000},
        '{1'b0, 25'h000_0024, 2'd1, 1'b0, 32'h2000_0000},
        '{1'b1, 25'h000_007C, 2'd2, 1'b1, 32'h2000_0000},
        '{1'b0, 25'h000_007C, 2'd2, 1'b0, 32'h2000_0000},
        '{1'b0, 25'h1FF_FFE0, 2'd0, 1'b0, 32'h200F_FFFF},
        '{1'b1, 25'h1FF_FFFC, 2'd2, 1'b0, 32'h200F_FFFC},
        '{1'b1, 25'h000_0A48, 2'd1, 1'b1, 32'h2000_0052},
        '{1'b0, 25'h000_0A48, 2'd1, 1'b0, 32'h2000_0052},
        '{1'b1, 25'h000_0A48, 2'd0, 1'b0, 32'h2000_0052},
        '{1'b0, 25'h000_0A48, 2'd1, 1'b0, 32'h2000_0052}
    };

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic        er;
        int          rc0;
        int          wc0;

        // R1: state during and after reset
        repeat (3) @(negedge clk);
        chk(s_ready && !m_valid && !s_rsp_valid, "R1", "outputs during reset",
            {29'h0, s_ready, m_valid, s_rsp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(s_ready && !m_valid && !s_rsp_valid, "R1", "outputs after reset",
            {29'h0, s_ready, m_valid, s_rsp_valid}, 32'h4);

        for (int v = 0; v < NV; v++) begin
            int          nb;
            int          bp;
            logic [31:0] unit;
            nb = 1 << VECS[v].sz;
            bp = int'((VECS[v].off >> 2) & 25'(nb * 8 - 1));
            unit = fetch_gold(VECS[v].exp_addr, nb);
            wc0 = wr_cnt;
            run_op(VECS[v].wr, VECS[v].off, VECS[v].sz, VECS[v].wbit, rd, er);
            chk(!er, "R4", "unexpected error", 32'(er), 32'h0);
            chk(last_rd_addr == VECS[v].exp_addr, "R2", "fetch address",
                last_rd_addr, VECS[v].exp_addr);
            chk(last_rd_size == VECS[v].sz, "R4", "fetch size",
                32'(last_rd_size), 32'(VECS[v].sz));
            if (!VECS[v].wr) begin
                chk(rd == {31'h0, unit[bp]}, "R3", "read bit", rd, {31'h0, unit[bp]});
                chk(wr_cnt == wc0, "R4", "read caused a memory write",
                    32'(wr_cnt), 32'(wc0));
            end else begin
                unit[bp] = VECS[v].wbit;
                for (int k = 0; k < nb; k++)
                    gold[(VECS[v].exp_addr[7:0] + k) & 8'hFF] = unit[k*8 +: 8];
                chk(rd == 32'h0, "R5", "write response data", rd, 32'h0);
                chk(wr_cnt == wc0 + 1, "R5", "write-back count",
                    32'(wr_cnt), 32'(wc0 + 1));
                chk(last_wr_addr == VECS[v].exp_addr && last_wr_size == VECS[v].sz,
                    "R5", "write-back address", last_wr_addr, VECS[v].exp_addr);
                chk(last_wr_data == unit, "R5", "write-back data", last_wr_data, unit);
                chk(fetch_mem(VECS[v].exp_addr, nb) == unit, "R5", "memory after write",
                    fetch_mem(VECS[v].exp_addr, nb), unit);
            end
        end

        // R6: fetch error on a write aborts with no write-back
        inj_rd = 1'b1;
        wc0 = wr_cnt;
        run_op(1'b1, 25'h000_0040, 2'd0, 1'b1, rd, er);
        chk(er == 1'b1, "R6", "fetch error not reported", 32'(er), 32'h1);
        chk(wr_cnt == wc0, "R6", "write-back after fetch error", 32'(wr_cnt), 32'(wc0));
        chk(mem[2] == gold[2], "R6", "memory changed", 32'(mem[2]), 32'(gold[2]));
        run_op(1'b0, 25'h000_0040, 2'd0, 1'b0, rd, er);
        chk(er == 1'b1 && rd == 32'h0, "R6", "read error response", rd, 32'h0);
        inj_rd = 1'b0;

        // R7: write-back error reported
        inj_wr = 1'b1;
        wc0 = wr_cnt;
        run_op(1'b1, 25'h000_0060, 2'd1, 1'b1, rd, er);
        chk(er == 1'b1, "R7", "write-back error not reported", 32'(er), 32'h1);
        chk(wr_cnt == wc0 + 1, "R7", "write-back attempt count", 32'(wr_cnt), 32'(wc0 + 1));
        inj_wr = 1'b0;

        // R9: invalid size code 3
        rc0 = rd_cnt;
        wc0 = wr_cnt;
        run_op(1'b1, 25'h000_0080, 2'd3, 1'b1, rd, er);
        chk(er == 1'b1, "R9", "bad size not rejected", 32'(er), 32'h1);
        chk(rd_cnt == rc0 && wr_cnt == wc0, "R9", "bad size touched memory",
            32'(rd_cnt + wr_cnt), 32'(rc0 + wc0));

        // after errors, normal traffic resumes
        run_op(1'b0, 25'h000_001C, 2'd0, 1'b0, rd, er);
        chk(!er && rd == {31'h0, gold[0][7]}, "R4", "read after errors",
            rd, {31'h0, gold[0][7]});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule